// File: doc/BRIEF.md
# Parallel Block String Matcher

This engine compares a whole block of subject bytes against up to eight configured pattern characters in a single clock. Each pattern slot, called a row, holds either one character or an inclusive byte range. Every row is compared with every byte of the block at the same time. The results form a row-by-column hit matrix. A six-bit operation code selects how that matrix is used, and the unused outputs stay at zero.

There are three operations:

- **Find** walks the matrix along its diagonals to locate a multi-character pattern. Blocks of one stream are fed in order, with a marker on the final block. The hit columns of the previous block are kept, so a pattern that spans a block boundary is still found. The absolute offset of the first match in the stream is reported together with the final block.
- **Class** returns one flag per byte. A byte is flagged when it matches any enabled row. It is typically used to flag blocks that contain special characters.
- **Substitute** rewrites every byte that matched a row. Each row can either supply a fixed replacement byte or XOR the byte with a mask, which gives case conversion when the row is a letter range.

Top module: `strm_match_engine`

## Requirements
- R1: After reset all outputs are zero and every row is disabled, so no byte can match.
- R2: A configuration write loads one row (enable, range flag, XOR flag, low byte, high byte, replacement byte) and takes effect from the next cycle. A disabled row never flags a byte. In a find it is skipped, meaning its pattern position matches any byte.
- R3: A row without the range flag matches only a byte equal to its low byte. With the range flag, rows 0 to 5 match any byte b with low <= b <= high. Rows 6 and 7 ignore the range flag and always compare for equality.
- R4: The class operation (op 6'b000010) sets bit c of the hit output when byte c of the block matches any enabled row. Byte c occupies data bits 8c+7 down to 8c.
- R5: The find operation (op 6'b000001) reports the smallest stream offset s such that every enabled row i matches the byte at offset s+i. Byte c of block k has offset 16k+c. The found flag and offset appear only on the output of the block marked last, and the first match stays reported even when later ones exist.
- R6: A find match whose pattern spans the boundary between two consecutive find blocks is detected.
- R7: A match that would need bytes beyond the end of the stream is not reported. A find with no enabled row reports not found, with offset zero.
- R8: The substitute operation (op 6'b000100) replaces each byte using the lowest-numbered enabled row that matches it. The replacement is the row's byte, or the input byte XOR the row's byte when the XOR flag is set. Bytes that match no row pass through unchanged.
- R9: Outputs that do not belong to the current operation are zero, and any other op code produces only the valid and last flags. Blocks carrying an operation other than find leave the find state of a stream in progress untouched.
- R10: Every input block produces exactly one output one cycle later, with the last flag copied from the input.
- R11: After a last block, the next find stream starts counting offsets from zero with no carried match state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Row configuration write strobe |
| cfg_row | input | 3 | Row index to write |
| cfg_en | input | 1 | Row enable |
| cfg_rng | input | 1 | Range compare flag (rows 0 to 5 only) |
| cfg_xor | input | 1 | Substitute by XOR instead of replacing |
| cfg_lo | input | 8 | Equality character or range low bound |
| cfg_hi | input | 8 | Range high bound |
| cfg_val | input | 8 | Replacement byte or XOR mask |
| in_valid | input | 1 | Input block valid |
| in_op | input | 6 | Operation code |
| in_data | input | 128 | Subject block, byte c at bits 8c+7:8c |
| in_last | input | 1 | Final block of the stream |
| out_valid | output | 1 | Output valid |
| out_last | output | 1 | Output belongs to a last block |
| out_found | output | 1 | Find matched somewhere in the stream |
| out_index | output | 16 | Absolute offset of the first match |
| out_hits | output | 16 | Per-byte class hit flags |
| out_data | output | 128 | Substituted block |

## Verification
The find operation is exercised with these patterns, each chosen to separate one kind of fault:

- A pattern inside one block and one repeated twice, which separate correct diagonal alignment from a wrong-column or last-match priority.
- A pattern split across a block edge and one in the third block of a stream, which expose a missing previous-block buffer or a wrong offset base.
- A partial pattern at the stream end, which must not be reported.
- A pattern with a disabled middle row, which must behave as a wildcard.

Class and substitute blocks are run with range rows, equality-only rows carrying a range flag, and overlapping rows. These show range decoding, row priority and passthrough of unmatched bytes. A class block placed inside a find stream, and an unknown op code, show that each operation affects only its own outputs and state.

// File: rtl/strm_pkg.sv
package strm_pkg;

    typedef logic [5:0] op_t;

    localparam op_t OP_FIND  = 6'b000001;
    localparam op_t OP_CLASS = 6'b000010;
    localparam op_t OP_SUBST = 6'b000100;

    typedef struct packed {
        logic       en;
        logic       rng;
        logic       xr;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] val;
    } row_cfg_t;

    // One matrix cell: disabled rows never hit.
    function automatic logic cell_hit(row_cfg_t r, logic [7:0] b);
        if (!r.en)
            return 1'b0;
        if (r.rng)
            return (b >= r.lo) && (b <= r.hi);
        return b == r.lo;
    endfunction

endpackage

// File: rtl/strm_row_cfg.sv
module strm_row_cfg
    import strm_pkg::*;
#(
    parameter int ROWS       = 8,
    parameter int RANGE_ROWS = 6,
    localparam int RW        = $clog2(ROWS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [RW-1:0]             row,
    input  row_cfg_t                  wdata,
    output row_cfg_t [ROWS-1:0]       cfg_q
);

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (we && row == RW'(i)) begin
                cfg_q[i]     <= wdata;
                // only the low rows own range comparators
                cfg_q[i].rng <= (i < RANGE_ROWS) ? wdata.rng : 1'b0;
            end
        end
    end

    // R2: a write with the enable clear disables that row
    a_r2_disable_write: assert property (@(posedge clk) disable iff (rst)
        (we && !wdata.en) |=> !cfg_q[$past(row)].en);

endmodule

// File: rtl/strm_matrix.sv
module strm_matrix
    import strm_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 16
) (
    input  row_cfg_t [ROWS-1:0]          cfg,
    input  logic [COLS*8-1:0]            data,
    output logic [ROWS-1:0][COLS-1:0]    hit
);

    // Every cell is independent: one comparator per row/byte pair.
    for (genvar i = 0; i < ROWS; i++) begin : g_r
        for (genvar c = 0; c < COLS; c++) begin : g_c
            assign hit[i][c] = cell_hit(cfg[i], data[c*8 +: 8]);
        end
    end

endmodule

// File: rtl/strm_find.sv
module strm_find #(
    parameter int ROWS  = 8,
    parameter int COLS  = 16,
    parameter int IDX_W = 16,
    localparam int CW   = $clog2(COLS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step,
    input  logic                         last,
    input  logic [ROWS-1:0]              en_mask,
    input  logic [ROWS-1:0][COLS-1:0]    hit,
    output logic                         res_found,
    output logic [IDX_W-1:0]             res_index
);

    logic [ROWS-1:0][COLS-1:0] prev_q;
    logic                      prev_v;
    logic [IDX_W-1:0]          off_q;
    logic                      found_q;
    logic [IDX_W-1:0]          idx_q;

    logic [COLS-1:0]  cand_prev, cand_cur;
    logic             p_any, c_any, new_found;
    logic [IDX_W-1:0] p_idx, c_idx, new_idx;

    // Diagonal AND chains: starts in the buffered block use the current
    // block for their tail; starts in a last block have no tail beyond it.
    always_comb begin
        for (int s = 0; s < COLS; s++) begin
            logic ok_p, ok_c;
            int   k, kk;
            ok_p = prev_v & (|en_mask);
            ok_c = last & (|en_mask);
            for (int i = 0; i < ROWS; i++) begin
                k  = s + i;
                kk = k - COLS;
                if (en_mask[i]) begin
                    if (k < COLS) begin
                        ok_p = ok_p & prev_q[i][k[CW-1:0]];
                        ok_c = ok_c & hit[i][k[CW-1:0]];
                    end else begin
                        ok_p = ok_p & hit[i][kk[CW-1:0]];
                        ok_c = 1'b0;
                    end
                end
            end
            cand_prev[s] = ok_p;
            cand_cur[s]  = ok_c;
        end
    end

    // Priority encoders: lowest column wins
    always_comb begin
        p_any = |cand_prev;
        c_any = |cand_cur;
        p_idx = '0;
        c_idx = '0;
        for (int s = COLS - 1; s >= 0; s--) begin
            if (cand_prev[s]) p_idx = IDX_W'(s);
            if (cand_cur[s])  c_idx = IDX_W'(s);
        end
    end

    assign new_found = p_any | c_any;
    assign new_idx   = p_any ? (off_q - IDX_W'(COLS) + p_idx) : (off_q + c_idx);
    assign res_found = found_q | new_found;
    assign res_index = found_q ? idx_q : (new_found ? new_idx : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            prev_v  <= 1'b0;
            off_q   <= '0;
            found_q <= 1'b0;
            idx_q   <= '0;
        end else if (step) begin
            if (last) begin
                prev_v  <= 1'b0;
                off_q   <= '0;
                found_q <= 1'b0;
                idx_q   <= '0;
            end else begin
                prev_q <= hit;
                prev_v <= 1'b1;
                off_q  <= off_q + IDX_W'(COLS);
                if (!found_q && new_found) begin
                    found_q <= 1'b1;
                    idx_q   <= new_idx;
                end
            end
        end
    end

    // R5: the first match of a stream is held until the stream ends
    a_r5_first_held: assert property (@(posedge clk) disable iff (rst)
        (found_q && !(step && last)) |=> (found_q && $stable(idx_q)));

    // R11: nothing carries into a new stream
    a_r11_fresh_stream: assert property (@(posedge clk) disable iff (rst)
        (step && last) |=> (!found_q && !prev_v));

endmodule

// File: rtl/strm_match_engine.sv
module strm_match_engine
    import strm_pkg::*;
#(
    parameter int ROWS       = 8,
    parameter int COLS       = 16,
    parameter int RANGE_ROWS = 6,
    parameter int IDX_W      = 16,
    localparam int RW        = $clog2(ROWS),
    localparam int DW        = COLS * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [RW-1:0]    cfg_row,
    input  logic             cfg_en,
    input  logic             cfg_rng,
    input  logic             cfg_xor,
    input  logic [7:0]       cfg_lo,
    input  logic [7:0]       cfg_hi,
    input  logic [7:0]       cfg_val,
    input  logic             in_valid,
    input  logic [5:0]       in_op,
    input  logic [DW-1:0]    in_data,
    input  logic             in_last,
    output logic             out_valid,
    output logic             out_last,
    output logic             out_found,
    output logic [IDX_W-1:0] out_index,
    output logic [COLS-1:0]  out_hits,
    output logic [DW-1:0]    out_data
);

    row_cfg_t                  wdata;
    row_cfg_t [ROWS-1:0]       cfg_q;
    logic [ROWS-1:0]           en_mask;
    logic [DW-1:0]             mat_data;
    logic [ROWS-1:0][COLS-1:0] hit;
    logic                      is_find, is_class, is_subst;
    logic                      res_found;
    logic [IDX_W-1:0]          res_index;
    logic [COLS-1:0]           hits_any;
    logic [DW-1:0]             sub_data;

    assign wdata = '{en: cfg_en, rng: cfg_rng, xr: cfg_xor,
                     lo: cfg_lo, hi: cfg_hi, val: cfg_val};

    assign is_find  = in_valid && (in_op == OP_FIND);
    assign is_class = in_valid && (in_op == OP_CLASS);
    assign is_subst = in_valid && (in_op == OP_SUBST);
    // the comparator matrix only sees data for an operation that uses it
    assign mat_data = (is_find || is_class || is_subst) ? in_data : '0;

    strm_row_cfg #(.ROWS(ROWS), .RANGE_ROWS(RANGE_ROWS)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .row(cfg_row),
        .wdata(wdata), .cfg_q(cfg_q)
    );

    for (genvar i = 0; i < ROWS; i++) begin : g_en
        assign en_mask[i] = cfg_q[i].en;
    end

    strm_matrix #(.ROWS(ROWS), .COLS(COLS)) u_mat (
        .cfg(cfg_q), .data(mat_data), .hit(hit)
    );

    strm_find #(.ROWS(ROWS), .COLS(COLS), .IDX_W(IDX_W)) u_find (
        .clk(clk), .rst(rst), .step(is_find), .last(in_last),
        .en_mask(en_mask), .hit(hit),
        .res_found(res_found), .res_index(res_index)
    );

    // Class flags and substitution, one column at a time
    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_comb begin
            logic [7:0] b, r;
            b           = mat_data[c*8 +: 8];
            r           = b;
            hits_any[c] = 1'b0;
            for (int i = ROWS - 1; i >= 0; i--) begin
                if (hit[i][c]) begin
                    hits_any[c] = 1'b1;
                    r = cfg_q[i].xr ? (b ^ cfg_q[i].val) : cfg_q[i].val;
                end
            end
            sub_data[c*8 +: 8] = r;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_found <= 1'b0;
            out_index <= '0;
            out_hits  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_last  <= in_valid && in_last;
            out_found <= (is_find && in_last) ? res_found : 1'b0;
            out_index <= (is_find && in_last) ? res_index : '0;
            out_hits  <= is_class ? hits_any : '0;
            out_data  <= is_subst ? sub_data : '0;
        end
    end

    // R10: one output per input block, one cycle later
    a_r10_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_idle_follow: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R5: found only reported alongside a last block
    a_r5_found_on_last: assert property (@(posedge clk) disable iff (rst)
        out_found |-> (out_valid && out_last));

    // R9: hit flags only for the class operation
    a_r9_hits_gated: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != OP_CLASS) |=> (out_hits == '0));

    // R9: rewritten data only for the substitute operation
    a_r9_data_gated: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != OP_SUBST) |=> (out_data == '0));

endmodule

// File: tb/sim_strm_match_engine.sv
module sim_strm_match_engine;
    import strm_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_row = '0;
    logic         cfg_en = 1'b0, cfg_rng = 1'b0, cfg_xor = 1'b0;
    logic [7:0]   cfg_lo = '0, cfg_hi = '0, cfg_val = '0;
    logic         in_valid = 1'b0;
    logic [5:0]   in_op = '0;
    logic [127:0] in_data = '0;
    logic         in_last = 1'b0;
    logic         out_valid, out_last, out_found;
    logic [15:0]  out_index;
    logic [15:0]  out_hits;
    logic [127:0] out_data;

    int nchk = 0;
    int nfail = 0;

    // behavioural model state
    bit         ren [8];
    bit         rrng[8];
    bit         rxr [8];
    logic [7:0] rlo [8];
    logic [7:0] rhi [8];
    logic [7:0] rval[8];
    logic [7:0] sq[$];

    always #10 clk = ~clk;

    strm_match_engine u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row),
        .cfg_en(cfg_en), .cfg_rng(cfg_rng), .cfg_xor(cfg_xor),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_val(cfg_val),
        .in_valid(in_valid), .in_op(in_op), .in_data(in_data),
        .in_last(in_last), .out_valid(out_valid), .out_last(out_last),
        .out_found(out_found), .out_index(out_index),
        .out_hits(out_hits), .out_data(out_data)
    );

    function automatic bit mhit(int i, logic [7:0] b);
        if (!ren[i]) return 1'b0;
        if (rrng[i] && i < 6) return (b >= rlo[i]) && (b <= rhi[i]);
        return b == rlo[i];
    endfunction

    function automatic logic [127:0] mkblk(string s, byte fill, int at);
        logic [127:0] d;
        for (int c = 0; c < 16; c++) d[c*8 +: 8] = fill;
        for (int k = 0; k < s.len(); k++)
            if (at + k < 16) d[(at+k)*8 +: 8] = s[k];
        return d;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfgw(int row, bit en, bit rng, bit xr,
                        logic [7:0] lo, logic [7:0] hi, logic [7:0] val);
        cfg_we = 1'b1; cfg_row = 3'(row); cfg_en = en; cfg_rng = rng;
        cfg_xor = xr; cfg_lo = lo; cfg_hi = hi; cfg_val = val;
        ren[row] = en; rrng[row] = rng; rxr[row] = xr;
        rlo[row] = lo; rhi[row] = hi; rval[row] = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_rows();
        for (int i = 0; i < 8; i++) cfgw(i, 0, 0, 0, 8'h00, 8'h00, 8'h00);
    endtask

    // Drive one block, predict, and compare on the following clock.
    task automatic send(logic [5:0] op, logic [127:0] d, bit last, string tag);
        logic [127:0] ed;
        logic [15:0]  eh;
        logic [15:0]  ei;
        bit           ef;
        ed = '0; eh = '0; ei = '0; ef = 1'b0;
        in_valid = 1'b1; in_op = op; in_data = d; in_last = last;
        if (op == OP_FIND) begin
            for (int c = 0; c < 16; c++) sq.push_back(d[c*8 +: 8]);
            if (last) begin
                bit anyen;
                anyen = 1'b0;
                for (int i = 0; i < 8; i++) anyen |= ren[i];
                for (int s = 0; s < sq.size() && !ef; s++) begin
                    bit ok;
                    ok = anyen;
                    for (int i = 0; i < 8; i++)
                        if (ren[i]) begin
                            if (s + i >= sq.size()) ok = 1'b0;
                            else if (!mhit(i, sq[s+i])) ok = 1'b0;
                        end
                    if (ok) begin ef = 1'b1; ei = 16'(s); end
                end
                sq.delete();
            end
        end else if (op == OP_CLASS) begin
            for (int c = 0; c < 16; c++)
                for (int i = 0; i < 8; i++)
                    if (mhit(i, d[c*8 +: 8])) eh[c] = 1'b1;
        end else if (op == OP_SUBST) begin
            for (int c = 0; c < 16; c++) begin
                logic [7:0] b, r;
                bit done;
                b = d[c*8 +: 8]; r = b; done = 1'b0;
                for (int i = 0; i < 8; i++)
                    if (!done && mhit(i, b)) begin
                        r = rxr[i] ? (b ^ rval[i]) : rval[i];
                        done = 1'b1;
                    end
                ed[c*8 +: 8] = r;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk({tag, " R10 valid"}, 128'(out_valid), 128'(1));
        chk({tag, " R10 last"},  128'(out_last),  128'(last));
        chk({tag, " found"},     128'(out_found), 128'(ef));
        chk({tag, " index"},     128'(out_index), 128'(ei));
        chk({tag, " hits"},      128'(out_hits),  128'(eh));
        chk({tag, " data"},      out_data,        ed);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            ren[i] = 0; rrng[i] = 0; rxr[i] = 0;
            rlo[i] = 0; rhi[i] = 0; rval[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 valid", 128'(out_valid), 128'(0));
        chk("R1 found", 128'(out_found), 128'(0));
        chk("R1 data",  out_data, 128'(0));
        send(OP_CLASS, mkblk("abcXYZ019", "#", 0), 0, "R1 no rows enabled");

        // R3/R4: range rows and equality-only rows
        cfgw(0, 1, 1, 0, "a", "z", 8'h00);
        cfgw(6, 1, 1, 0, "0", "9", 8'h00);
        send(OP_CLASS, mkblk("aQ0z5 m9#0", "-", 2), 0, "R3 R4 class range");
        cfgw(2, 1, 1, 0, "A", "Z", 8'h00);
        send(OP_CLASS, mkblk("Hello World 42!", "*", 0), 0, "R4 class mixed");
        clear_rows();

        // R5: single block find
        cfgw(0, 1, 0, 0, "a", 8'h00, 8'h00);
        cfgw(1, 1, 0, 0, "b", 8'h00, 8'h00);
        cfgw(2, 1, 0, 0, "c", 8'h00, 8'h00);
        send(OP_FIND, mkblk("abc", ".", 5), 1, "R5 find in block");
        send(OP_FIND, mkblk("abcxxabc", ".", 0), 0, "R5 first of two");
        send(OP_FIND, mkblk("abc", ".", 3), 1, "R5 first of two end");

        // R6: spanning a block edge
        send(OP_FIND, mkblk("ab", "-", 14), 0, "R6 span a");
        send(OP_FIND, mkblk("c", "-", 0), 1, "R6 span b");

        // R5/R11: third block, offsets restart after previous stream
        send(OP_FIND, mkblk("", "-", 0), 0, "R11 s0");
        send(OP_FIND, mkblk("", "-", 0), 0, "R11 s1");
        send(OP_FIND, mkblk("abc", "-", 3), 1, "R11 R5 s2 offset");

        // R7: partial at stream end
        send(OP_FIND, mkblk("ab", "-", 14), 1, "R7 partial tail");

        // R9: class block inside a find stream
        send(OP_FIND, mkblk("ab", "-", 14), 0, "R9 find a");
        send(OP_CLASS, mkblk("cab", "-", 0), 0, "R9 interleaved class");
        send(OP_FIND, mkblk("c", "-", 0), 1, "R9 find b");

        // R2: disabled middle row acts as a wildcard
        cfgw(1, 0, 0, 0, "b", 8'h00, 8'h00);
        send(OP_FIND, mkblk("axc", "-", 9), 1, "R2 wildcard row");

        // R7: nothing enabled, nothing found
        clear_rows();
        send(OP_FIND, mkblk("abc", "-", 0), 1, "R7 no rows");

        // R8: substitution, case conversion and priority
        cfgw(0, 1, 1, 1, "a", "z", 8'h20);
        cfgw(1, 1, 0, 0, ".", 8'h00, "_");
        cfgw(3, 1, 0, 0, "q", 8'h00, "!");
        send(OP_SUBST, mkblk("quick.brown Fox", "%", 0), 0, "R8 subst");
        cfgw(7, 1, 1, 0, "%", 8'h00, "=");
        send(OP_SUBST, mkblk("a.b", "%", 6), 1, "R8 R3 subst eq row");

        // R9: unknown op code
        send(6'b001000, mkblk("q.a", "%", 0), 1, "R9 unknown op");

        @(negedge clk);
        chk("R10 idle", 128'(out_valid), 128'(0));

        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule